// File: doc/BRIEF.md
# Buffered Dual-Port Host Link Controller

This block connects a slow byte-wide host I/O bus to two byte-wide link adapters. The fast port puts a receive FIFO and a transmit FIFO between the host and its adapter. The block takes bytes from the adapter, and hands bytes to it, without waiting for the host. The host therefore moves whole blocks with string I/O and tracks FIFO fill levels instead of polling every byte. The slow port has no buffering. It works as a plain polled single-byte adapter interface.

Each port owns an 8-byte address window. By default the fast port answers at 0x150 and the slow port at 0x158. A configuration bit exchanges the two windows. Each FIFO reports empty, half-full and full. Each port has its own interrupt enables: the fast port can interrupt on the receive FIFO reaching half-full and on the transmit FIFO becoming full. A 4-bit switch value can be read back, so that up to 16 boards in one host can be told apart.

Top module: `hlk_link_ctrl`

## Requirements
- R1: After reset both FIFOs are empty, both interrupts are low, `fa_tx_valid` and `sa_tx_valid` are low, and the windows are not exchanged.
- R2: The fast port stores a byte from its adapter in every cycle in which `fa_rx_valid` is high and the receive FIFO is not full. `fa_rx_ack` is high in exactly that cycle. Reads of window offset 0 return the stored bytes in arrival order.
- R3: Host writes to window offset 1 of the fast port enter the transmit FIFO. The FIFO presents them on `fa_tx_data` in write order, with `fa_tx_valid` high while it is not empty. A byte leaves in a cycle where `fa_tx_ready` is also high.
- R4: The fast status registers are at offset 2 (receive) and offset 3 (transmit). Bit 0 is empty, bit 1 is half-full (count at least DEPTH/2), bit 2 is full (count equal to DEPTH) and bit 3 is the sticky error flag. The other bits read 0.
- R5: A host write to offset 1 while the transmit FIFO is full is dropped and sets the transmit error flag. Any write to offset 3 clears that flag.
- R6: A host read of offset 0 while the receive FIFO is empty returns 0x00 and sets the receive error flag. Any write to offset 2 clears that flag.
- R7: Bit 4 of a write to offset 2 sets the fast receive interrupt enable, and bit 4 of a write to offset 3 sets the fast transmit interrupt enable. `irq_fast` is high while (receive enable and receive half-full) or (transmit enable and transmit full).
- R8: On the slow port, offset 2 bit 0 shows `sa_rx_valid`. A read of offset 0 returns `sa_rx_data` and pulses `sa_rx_ack` in that cycle when `sa_rx_valid` is high. A write to offset 1 with the holding register idle loads `sa_tx_data` and raises `sa_tx_valid` until a cycle with `sa_tx_ready` high. A write while busy is dropped. Offset 3 bit 0 reads 1 when the holding register is idle.
- R9: Bit 4 of writes to slow offsets 2 and 3 sets the slow receive and transmit interrupt enables. `irq_slow` is high while (receive enable and `sa_rx_valid`) or (transmit enable and holding register idle).
- R10: Window A is 0x150 to 0x157 and window B is 0x158 to 0x15F. Reads outside both windows return 0x00, and writes outside them change nothing.
- R11: Offset 4 of either window is the configuration register. Its bit 7 is the exchange bit. With the bit at 0, window A is the fast port and window B the slow port. With the bit at 1, the roles are reversed.
- R12: A read of offset 4 returns the exchange bit in bit 7 and `board_id` in bits 3:0, with bits 6:4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | AW | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the strobe cycle |
| board_id | input | 4 | Board identity switches |
| fa_rx_valid | input | 1 | Fast adapter has a received byte |
| fa_rx_data | input | 8 | Fast adapter received byte |
| fa_rx_ack | output | 1 | Received byte stored this cycle |
| fa_tx_valid | output | 1 | Byte offered to fast adapter |
| fa_tx_data | output | 8 | Byte offered to fast adapter |
| fa_tx_ready | input | 1 | Fast adapter accepts a byte |
| sa_rx_valid | input | 1 | Slow adapter has a received byte |
| sa_rx_data | input | 8 | Slow adapter received byte |
| sa_rx_ack | output | 1 | Slow received byte taken by host |
| sa_tx_valid | output | 1 | Byte offered to slow adapter |
| sa_tx_data | output | 8 | Byte offered to slow adapter |
| sa_tx_ready | input | 1 | Slow adapter accepts a byte |
| irq_fast | output | 1 | Fast port interrupt |
| irq_slow | output | 1 | Slow port interrupt |

## Verification
The fast path is driven with three kinds of stimulus. A short three-byte transmit burst with the adapter stalled checks ordering and the not-empty level. A receive stream stopped one byte short of half and then one byte past it separates the half-full threshold and its interrupt from an off-by-one. Full-depth streams in both directions, plus one extra byte on each, show that nothing is lost and nothing extra is accepted at the full boundary. The slow port is tried with idle, busy and handed-off holding states. The same writes are repeated with the windows exchanged, which proves that the address decode, and not the offset alone, selects the port.

// File: rtl/hlk_pkg.sv
package hlk_pkg;
   localparam int BYTE_W   = 8;
   localparam int OFS_W    = 3;
   // register offsets inside one port window
   localparam logic [OFS_W-1:0] OFS_RXD = 3'd0;
   localparam logic [OFS_W-1:0] OFS_TXD = 3'd1;
   localparam logic [OFS_W-1:0] OFS_RXS = 3'd2;
   localparam logic [OFS_W-1:0] OFS_TXS = 3'd3;
   localparam logic [OFS_W-1:0] OFS_CFG = 3'd4;
   // bit positions in status / control bytes
   localparam int B_EMPTY = 0;
   localparam int B_HALF  = 1;
   localparam int B_FULL  = 2;
   localparam int B_ERR   = 3;
   localparam int B_IEN   = 4;
   localparam int B_SWAP  = 7;

   typedef struct packed {
      logic full;
      logic half;
      logic empty;
   } fifo_lvl_t;
endpackage

// File: rtl/hlk_fifo.sv
module hlk_fifo
   import hlk_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          push_ok,
   output logic          pop_ok,
   output fifo_lvl_t     lvl
);
   localparam int  PW   = $clog2(DEPTH);
   localparam int  CW   = PW + 1;
   localparam bit  POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("hlk_fifo: DEPTH must be even and at least 4");
   end
   if (DW < 1) begin : g_bad_width
      $error("hlk_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wnext, rnext;
   logic [CW-1:0] count;

   // pointer wrap: free for a power-of-two depth, compare otherwise
   if (POW2) begin : g_wrap_free
      assign wnext = wptr + PW'(1);
      assign rnext = rptr + PW'(1);
   end else begin : g_wrap_cmp
      assign wnext = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
      assign rnext = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
   end

   assign lvl.empty = (count == '0);
   assign lvl.full  = (count == CW'(DEPTH));
   assign lvl.half  = (count >= CW'(DEPTH / 2));
   assign push_ok   = push && !lvl.full;
   assign pop_ok    = pop && !lvl.empty;
   assign rdata     = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wnext;
         if (pop_ok)  rptr <= rnext;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R2
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !lvl.full) |=> (count == $past(count) + CW'(1)));
   // R4
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count <= CW'(DEPTH)));
endmodule

// File: rtl/hlk_fast_port.sv
module hlk_fast_port
   import hlk_pkg::*;
#(
   parameter int DEPTH = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ack,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready
);
   fifo_lvl_t         rx_lvl, tx_lvl;
   logic [BYTE_W-1:0] rx_q;
   logic              rx_pop, tx_push, rx_pop_ok, tx_push_ok, tx_pop_ok;
   logic              ien_rx, ien_tx, err_rx, err_tx;
   logic              wr_txs, wr_rxs;

   assign rx_pop  = sel && rd && (ofs == OFS_RXD);
   assign tx_push = sel && wr && (ofs == OFS_TXD);
   assign wr_rxs  = sel && wr && (ofs == OFS_RXS);
   assign wr_txs  = sel && wr && (ofs == OFS_TXS);

   hlk_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .push(rx_valid), .wdata(rx_data), .pop(rx_pop), .rdata(rx_q),
      .push_ok(rx_ack), .pop_ok(rx_pop_ok), .lvl(rx_lvl));

   hlk_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(wdata), .pop(tx_ready), .rdata(tx_data),
      .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .lvl(tx_lvl));

   assign tx_valid = !tx_lvl.empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_rx <= 1'b0;
         ien_tx <= 1'b0;
         err_rx <= 1'b0;
         err_tx <= 1'b0;
      end else begin
         if (wr_rxs) begin
            ien_rx <= wdata[B_IEN];
            err_rx <= 1'b0;
         end else if (rx_pop && !rx_pop_ok) begin
            err_rx <= 1'b1;
         end
         if (wr_txs) begin
            ien_tx <= wdata[B_IEN];
            err_tx <= 1'b0;
         end else if (tx_push && !tx_push_ok) begin
            err_tx <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_RXD: rdata = rx_lvl.empty ? '0 : rx_q;
         OFS_RXS: rdata = {4'b0, err_rx, rx_lvl.full, rx_lvl.half, rx_lvl.empty};
         OFS_TXS: rdata = {4'b0, err_tx, tx_lvl.full, tx_lvl.half, tx_lvl.empty};
         default: rdata = '0;
      endcase
   end

   assign irq = (ien_rx && rx_lvl.half) || (ien_tx && tx_lvl.full);

   // R2
   rx_ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |-> rx_valid);
   // R5
   tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_tx && !wr_txs) |=> err_tx);
   // R6
   rx_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_lvl.empty && !wr_rxs) |=> err_rx);
   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/hlk_slow_port.sv
module hlk_slow_port
   import hlk_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ack,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready
);
   logic ien_rx, ien_tx, hold;
   logic [BYTE_W-1:0] hold_q;

   assign rx_ack   = sel && rd && (ofs == OFS_RXD) && rx_valid;
   assign tx_valid = hold;
   assign tx_data  = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold   <= 1'b0;
         hold_q <= '0;
         ien_rx <= 1'b0;
         ien_tx <= 1'b0;
      end else begin
         if (hold && tx_ready) begin
            hold <= 1'b0;
         end else if (!hold && sel && wr && (ofs == OFS_TXD)) begin
            hold   <= 1'b1;
            hold_q <= wdata;
         end
         if (sel && wr && (ofs == OFS_RXS)) ien_rx <= wdata[B_IEN];
         if (sel && wr && (ofs == OFS_TXS)) ien_tx <= wdata[B_IEN];
      end
   end

   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_RXD: rdata = rx_valid ? rx_data : '0;
         OFS_RXS: rdata = {7'b0, rx_valid};
         OFS_TXS: rdata = {7'b0, !hold};
         default: rdata = '0;
      endcase
   end

   assign irq = (ien_rx && rx_valid) || (ien_tx && !hold);

   // R8
   slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
   // R8
   slow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/hlk_link_ctrl.sv
module hlk_link_ctrl
   import hlk_pkg::*;
#(
   parameter int          AW     = 10,
   parameter int          DEPTH  = 1024,
   parameter logic [AW-1:0] BASE_A = 10'h150,
   parameter logic [AW-1:0] BASE_B = 10'h158
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic [3:0]        board_id,
   input  logic              fa_rx_valid,
   input  logic [BYTE_W-1:0] fa_rx_data,
   output logic              fa_rx_ack,
   output logic              fa_tx_valid,
   output logic [BYTE_W-1:0] fa_tx_data,
   input  logic              fa_tx_ready,
   input  logic              sa_rx_valid,
   input  logic [BYTE_W-1:0] sa_rx_data,
   output logic              sa_rx_ack,
   output logic              sa_tx_valid,
   output logic [BYTE_W-1:0] sa_tx_data,
   input  logic              sa_tx_ready,
   output logic              irq_fast,
   output logic              irq_slow
);
   localparam int HW = AW - OFS_W;

   if (AW <= OFS_W) begin : g_bad_aw
      $error("hlk_link_ctrl: AW too small");
   end
   if (BASE_A[OFS_W-1:0] != '0 || BASE_B[OFS_W-1:0] != '0) begin : g_bad_align
      $error("hlk_link_ctrl: window bases must be 8-byte aligned");
   end
   if (BASE_A[AW-1:OFS_W] == BASE_B[AW-1:OFS_W]) begin : g_bad_overlap
      $error("hlk_link_ctrl: windows overlap");
   end

   logic             swap, hit_a, hit_b, sel_fast, sel_slow, cfg_hit;
   logic [OFS_W-1:0] ofs;
   logic [HW-1:0]    win;
   logic [BYTE_W-1:0] fast_rd, slow_rd;

   assign ofs      = host_addr[OFS_W-1:0];
   assign win      = host_addr[AW-1:OFS_W];
   assign hit_a    = (win == BASE_A[AW-1:OFS_W]);
   assign hit_b    = (win == BASE_B[AW-1:OFS_W]);
   assign sel_fast = swap ? hit_b : hit_a;
   assign sel_slow = swap ? hit_a : hit_b;
   assign cfg_hit  = (hit_a || hit_b) && (ofs == OFS_CFG);

   always_ff @(posedge clk) begin
      if (!rst_n)                  swap <= 1'b0;
      else if (host_wr && cfg_hit) swap <= host_wdata[B_SWAP];
   end

   hlk_fast_port #(.DEPTH(DEPTH)) u_fast (
      .clk(clk), .rst_n(rst_n), .sel(sel_fast), .wr(host_wr), .rd(host_rd),
      .ofs(ofs), .wdata(host_wdata), .rdata(fast_rd), .irq(irq_fast),
      .rx_valid(fa_rx_valid), .rx_data(fa_rx_data), .rx_ack(fa_rx_ack),
      .tx_valid(fa_tx_valid), .tx_data(fa_tx_data), .tx_ready(fa_tx_ready));

   hlk_slow_port u_slow (
      .clk(clk), .rst_n(rst_n), .sel(sel_slow), .wr(host_wr), .rd(host_rd),
      .ofs(ofs), .wdata(host_wdata), .rdata(slow_rd), .irq(irq_slow),
      .rx_valid(sa_rx_valid), .rx_data(sa_rx_data), .rx_ack(sa_rx_ack),
      .tx_valid(sa_tx_valid), .tx_data(sa_tx_data), .tx_ready(sa_tx_ready));

   always_comb begin
      if (cfg_hit)       host_rdata = {swap, 3'b0, board_id};
      else if (sel_fast) host_rdata = fast_rd;
      else if (sel_slow) host_rdata = slow_rd;
      else               host_rdata = '0;
   end

   // R11
   swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && (hit_a || hit_b)) |=> $stable(swap));
   // R10
   outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_a || hit_b) |-> (host_rdata == '0));
endmodule

// File: tb/sim_hlk_link_ctrl.sv
module sim_hlk_link_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] host_addr = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic [3:0] board_id = 4'hA;
   logic       fa_rx_valid = 1'b0, fa_rx_ack, fa_tx_valid, fa_tx_ready = 1'b0;
   logic [7:0] fa_rx_data = '0, fa_tx_data;
   logic       sa_rx_valid = 1'b0, sa_rx_ack, sa_tx_valid, sa_tx_ready = 1'b0;
   logic [7:0] sa_rx_data = '0, sa_tx_data;
   logic       irq_fast, irq_slow;

   int errors = 0;
   int checks = 0;
   int ncap   = 0;
   logic [7:0] cap [0:2047];

   always #5 clk = ~clk;

   hlk_link_ctrl u0 (.*);

   always @(posedge clk)
      if (fa_tx_valid && fa_tx_ready && ncap < 2048) begin
         cap[ncap] <= fa_tx_data;
         ncap      <= ncap + 1;
      end

   // {is_read, addr, write data, expected read}
   localparam logic [26:0] TBL [0:15] = '{
      {1'b1, 10'h154, 8'h00, 8'h0A},   // R12 id, no swap
      {1'b1, 10'h152, 8'h00, 8'h01},   // R1 rx empty
      {1'b1, 10'h153, 8'h00, 8'h01},   // R1 tx empty
      {1'b1, 10'h15A, 8'h00, 8'h00},   // R8 slow rx none
      {1'b1, 10'h15B, 8'h00, 8'h01},   // R8 slow tx idle
      {1'b0, 10'h151, 8'h11, 8'h00},
      {1'b0, 10'h151, 8'h22, 8'h00},
      {1'b0, 10'h151, 8'h33, 8'h00},
      {1'b1, 10'h153, 8'h00, 8'h00},   // R4 not empty, below half
      {1'b1, 10'h150, 8'h00, 8'h00},   // R6 empty read gives 0
      {1'b1, 10'h152, 8'h00, 8'h09},   // R6 error flag set
      {1'b0, 10'h152, 8'h00, 8'h00},
      {1'b1, 10'h152, 8'h00, 8'h01},   // R6 flag cleared
      {1'b1, 10'h160, 8'h00, 8'h00},   // R10 outside window
      {1'b0, 10'h149, 8'h44, 8'h00},   // R10 write outside window
      {1'b1, 10'h15C, 8'h00, 8'h0A}    // R12 id in window B
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic feed(input int n, input int start, output int misses);
      misses = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fa_rx_valid = 1'b1; fa_rx_data = 8'(start + i);
         #1 if (!fa_rx_ack) misses++;
      end
      @(negedge clk);
      fa_rx_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int miss, bad, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      check("R1 irq_fast", {7'b0, irq_fast}, 8'h00);
      check("R1 irq_slow", {7'b0, irq_slow}, 8'h00);
      check("R1 fa_tx_valid", {7'b0, fa_tx_valid}, 8'h00);
      check("R1 sa_tx_valid", {7'b0, sa_tx_valid}, 8'h00);

      for (int i = 0; i < 16; i++) begin
         if (TBL[i][26]) begin
            hread(TBL[i][25:16], d);
            check($sformatf("table %0d (R4/R6/R10/R12)", i), d, TBL[i][7:0]);
         end else begin
            hwrite(TBL[i][25:16], TBL[i][15:8]);
         end
      end

      // R3 drain of three bytes, R10 stray write absent
      fa_tx_ready = 1'b1;
      repeat (6) @(negedge clk);
      fa_tx_ready = 1'b0;
      check("R3/R10 count", 8'(ncap), 8'd3);
      check("R3 byte0", cap[0], 8'h11);
      check("R3 byte1", cap[1], 8'h22);
      check("R3 byte2", cap[2], 8'h33);

      // R2 / R7 receive half threshold
      hwrite(10'h152, 8'h10);
      feed(511, 0, miss);
      check("R2 ack misses", 8'(miss), 8'd0);
      hread(10'h152, d);
      check("R4 rx below half", d, 8'h00);
      check("R7 irq below half", {7'b0, irq_fast}, 8'h00);
      feed(1, 511, miss);
      hread(10'h152, d);
      check("R4 rx half", d, 8'h02);
      check("R7 irq at half", {7'b0, irq_fast}, 8'h01);
      feed(512, 512, miss);
      hread(10'h152, d);
      check("R4 rx full", d, 8'h06);
      @(negedge clk);
      fa_rx_valid = 1'b1; fa_rx_data = 8'hFF;
      #1 check("R2 no ack when full", {7'b0, fa_rx_ack}, 8'h00);
      @(negedge clk);
      fa_rx_valid = 1'b0;
      bad = 0;
      for (int i = 0; i < 1024; i++) begin
         hread(10'h150, d);
         if (d !== 8'(i)) bad++;
      end
      check("R2 order mismatches", 8'(bad), 8'd0);
      hread(10'h152, d);
      check("R4 rx empty again", d, 8'h01);
      check("R7 irq cleared", {7'b0, irq_fast}, 8'h00);

      // R5 / R7 transmit full and overflow
      hwrite(10'h153, 8'h10);
      for (int i = 0; i < 1024; i++) hwrite(10'h151, 8'(i) ^ 8'h5A);
      hread(10'h153, d);
      check("R4 tx full", d, 8'h06);
      check("R7 irq tx full", {7'b0, irq_fast}, 8'h01);
      hwrite(10'h151, 8'hEE);
      hread(10'h153, d);
      check("R5 overflow flag", d, 8'h0E);
      hwrite(10'h153, 8'h10);
      hread(10'h153, d);
      check("R5 flag cleared", d, 8'h06);
      base = ncap;
      fa_tx_ready = 1'b1;
      repeat (1030) @(negedge clk);
      fa_tx_ready = 1'b0;
      check("R5 drained count/4", 8'((ncap - base) / 4), 8'd0);
      bad = 0;
      for (int i = 0; i < 1024; i++) if (cap[base + i] !== (8'(i) ^ 8'h5A)) bad++;
      check("R3 full order mismatches", 8'(bad), 8'd0);
      check("R5 dropped byte absent", 8'(ncap - base - 1024), 8'd0);

      // R8 / R9 slow port
      hwrite(10'h15B, 8'h10);
      check("R9 irq tx idle", {7'b0, irq_slow}, 8'h01);
      hwrite(10'h159, 8'h77);
      check("R8 slow valid", {7'b0, sa_tx_valid}, 8'h01);
      check("R8 slow data", sa_tx_data, 8'h77);
      check("R9 irq busy", {7'b0, irq_slow}, 8'h00);
      hread(10'h15B, d);
      check("R8 slow busy status", d, 8'h00);
      hwrite(10'h159, 8'h88);
      check("R8 busy write dropped", sa_tx_data, 8'h77);
      @(negedge clk); sa_tx_ready = 1'b1;
      @(negedge clk); sa_tx_ready = 1'b0;
      check("R8 slow released", {7'b0, sa_tx_valid}, 8'h00);
      hwrite(10'h15B, 8'h00);
      sa_rx_valid = 1'b1; sa_rx_data = 8'h5A;
      hread(10'h15A, d);
      check("R8 slow rx status", d, 8'h01);
      @(negedge clk);
      host_addr = 10'h158; host_rd = 1'b1;
      #1 begin
         check("R8 slow rx data", host_rdata, 8'h5A);
         check("R8 slow rx ack", {7'b0, sa_rx_ack}, 8'h01);
      end
      @(negedge clk); host_rd = 1'b0;
      hwrite(10'h15A, 8'h10);
      check("R9 irq rx", {7'b0, irq_slow}, 8'h01);
      sa_rx_valid = 1'b0;
      #1 check("R9 irq rx gone", {7'b0, irq_slow}, 8'h00);

      // R11 window exchange
      hwrite(10'h154, 8'h80);
      hread(10'h15C, d);
      check("R12 swap bit and id", d, 8'h8A);
      hwrite(10'h151, 8'hC3);
      check("R11 A goes to slow", sa_tx_data, 8'hC3);
      check("R11 fast untouched", {7'b0, fa_tx_valid}, 8'h00);
      hwrite(10'h159, 8'h3C);
      check("R11 B goes to fast", fa_tx_data, 8'h3C);
      check("R11 fast valid", {7'b0, fa_tx_valid}, 8'h01);
      hwrite(10'h15C, 8'h00);
      hread(10'h154, d);
      check("R11 swap restored", d, 8'h0A);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule